// File: doc/BRIEF.md
# Tagged-Token Firing Stage

This block sits at the front of a dataflow processing element's cyclic pipeline. It accepts tagged tokens, one per cycle, and for each token reads the target instruction word from a small local program memory. A token whose instruction takes one operand fires immediately. A token whose instruction takes two operands looks up a slot addressed directly by its frame number and instruction address. If that slot is empty, the token parks there and the issue slot of that cycle is marked as an explicit bubble. If the slot is occupied, the pair fires and the slot is freed. Fired instructions leave on a registered issue port with opcode, tag and two operands.

An optional threaded mode lets one fired instruction start a straight-line sequence. The following program words are issued one per cycle, and token intake is paused until a word flagged as the thread's last has gone out. Values inside a thread travel through a small register file rather than through tokens. The head's operands are loaded into registers 0 and 1, and the execution stage can write any register through a dedicated port.

Top module: `tok_fire_unit`

## Requirements
- R1: After reset the unit shows no issue, no bubble and no continuation, holds `tok_ready` high, and every match slot is empty.
- R2: A token whose instruction word has the dyadic bit clear issues in the next cycle with `iss_a` equal to the token value, `iss_b` zero, `iss_cont` low and the tag of the token.
- R3: A token whose instruction is dyadic and whose slot {frame, address} is empty is stored. In the next cycle `iss_valid` stays low and `iss_bubble` is high.
- R4: A dyadic token whose slot is occupied issues exactly once in the next cycle. `iss_a` is the port-0 (left) value and `iss_b` the port-1 (right) value, whichever arrived first, and the slot becomes empty again.
- R5: If both tokens of a pair arrive on the same port, the newly arriving value goes to `iss_a` when the stored one came on port 1, and to `iss_b` when it came on port 0.
- R6: Slots are keyed by both frame and address, so pairs for different frames or addresses interleave without interference and each issues with its own tag and opcode.
- R7: A program word is laid out as opcode in bits [OP_W-1:0], dyadic flag at bit OP_W, end-of-thread flag at bit OP_W+1, source register A in the next RIDX_W bits and source register B in the RIDX_W bits above that.
- R8: With `thread_en` high, a token-fired instruction whose end-of-thread flag is clear is followed in consecutive cycles by the words at the following addresses. These issue with `iss_cont` high and the head's frame, up to and including the first word whose end-of-thread flag is set. `tok_ready` is low throughout, and a token held during the thread is accepted afterwards.
- R9: Every token fire loads its `iss_a` and `iss_b` values into registers 0 and 1. Continuation words take their operands from the registers named in their source fields. `rf_we` writes the register `rf_widx`, but a same-cycle load of register 0 or 1 wins.
- R10: With `thread_en` low, the end-of-thread flag is ignored. Every fired instruction issues alone and `tok_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_en | input | 1 | Enables threaded issue of sequences |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Unit can take a token this cycle |
| tok_frame | input | FRAME_W | Frame number of the token tag |
| tok_addr | input | ADDR_W | Instruction address of the token tag |
| tok_port | input | 1 | Operand side: 0 left, 1 right |
| tok_data | input | DATA_W | Token value |
| im_we | input | 1 | Program memory write strobe |
| im_waddr | input | ADDR_W | Program memory write address |
| im_wdata | input | IW_W | Program word written |
| rf_we | input | 1 | Register write strobe from the execution stage |
| rf_widx | input | RIDX_W | Register written |
| rf_wdata | input | DATA_W | Value written |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_bubble | output | 1 | Slot left empty by a parked first operand |
| iss_cont | output | 1 | Issued word is a thread continuation |
| iss_opcode | output | OP_W | Opcode of the issued word |
| iss_frame | output | FRAME_W | Frame tag of the issued word |
| iss_addr | output | ADDR_W | Address of the issued word |
| iss_a | output | DATA_W | First operand |
| iss_b | output | DATA_W | Second operand |

## Verification
The bench uses the default sizes: 2-bit frames, 4-bit addresses, 16-bit data, 6-bit opcodes and four registers. With these sizes several frames can target the same instruction address, so keying by frame as well as address is exercised on a 64-slot store. A three-word thread fits in the 16-word program memory. A register outside the head-loaded pair (register 2) can be preset through the write port to show that continuation operands really come from the register file.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_RUN  = 1'b1
  } thr_state_e;
endpackage

// File: rtl/tfu_match_store.sv
module tfu_match_store #(
  parameter int KEY_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  rd_key,
  output logic              rd_hit,
  output logic              rd_port,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              wr_port,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << KEY_W;

  logic              pres [DEPTH];
  logic              side [DEPTH];
  logic [DATA_W-1:0] held [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = (wr_key == KEY_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres[g] <= 1'b0;
      end else if (sel && wr_set) begin
        pres[g] <= 1'b1;
      end else if (sel && wr_clr) begin
        pres[g] <= 1'b0;
      end
    end
    always_ff @(posedge clk) begin
      if (sel && wr_set) begin
        side[g] <= wr_port;
        held[g] <= wr_data;
      end
    end
  end

  assign rd_hit  = pres[rd_key];
  assign rd_port = side[rd_key];
  assign rd_data = held[rd_key];
endmodule

// File: rtl/tfu_imem.sv
module tfu_imem #(
  parameter int ADDR_W = 4,
  parameter int IW_W   = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [IW_W-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr_tok,
  output logic [IW_W-1:0]   rdata_tok,
  input  logic [ADDR_W-1:0] raddr_thr,
  output logic [IW_W-1:0]   rdata_thr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [IW_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata_tok = words[raddr_tok];
  assign rdata_thr = words[raddr_thr];
endmodule

// File: rtl/tfu_regfile.sv
module tfu_regfile #(
  parameter int NREG   = 4,
  parameter int DATA_W = 16,
  localparam int RIDX_W = (NREG > 2) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_a,
  input  logic [DATA_W-1:0] ld_b,
  input  logic              wr_en,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RIDX_W-1:0] ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [RIDX_W-1:0] rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit_ext;
    assign hit_ext = wr_en && (wr_idx == RIDX_W'(g));
    if (g < 2) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)        regs[g] <= '0;
        else if (ld_en)    regs[g] <= (g == 0) ? ld_a : ld_b;
        else if (hit_ext)  regs[g] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)        regs[g] <= '0;
        else if (hit_ext)  regs[g] <= wr_data;
      end
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
endmodule

// File: rtl/tfu_thread_seq.sv
module tfu_thread_seq
  import tfu_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int FRAME_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic               cur_last,
  output logic               busy,
  output logic [ADDR_W-1:0]  pc,
  output logic [FRAME_W-1:0] frame
);
  thr_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TS_IDLE;
      pc    <= '0;
      frame <= '0;
    end else begin
      case (state)
        TS_IDLE: begin
          if (start) begin
            state <= TS_RUN;
            pc    <= start_addr + 1'b1;
            frame <= start_frame;
          end
        end
        TS_RUN: begin
          pc <= pc + 1'b1;
          if (cur_last) state <= TS_IDLE;
        end
        default: state <= TS_IDLE;
      endcase
    end
  end

  assign busy = (state == TS_RUN);
endmodule

// File: rtl/tok_fire_unit.sv
module tok_fire_unit #(
  parameter int FRAME_W = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 6,
  parameter int NREG    = 4,
  localparam int RIDX_W = (NREG > 2) ? $clog2(NREG) : 1,
  localparam int IW_W   = OP_W + 2 + 2 * RIDX_W,
  localparam int KEY_W  = FRAME_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               thread_en,
  input  logic               tok_valid,
  output logic               tok_ready,
  input  logic [FRAME_W-1:0] tok_frame,
  input  logic [ADDR_W-1:0]  tok_addr,
  input  logic               tok_port,
  input  logic [DATA_W-1:0]  tok_data,
  input  logic               im_we,
  input  logic [ADDR_W-1:0]  im_waddr,
  input  logic [IW_W-1:0]    im_wdata,
  input  logic               rf_we,
  input  logic [RIDX_W-1:0]  rf_widx,
  input  logic [DATA_W-1:0]  rf_wdata,
  output logic               iss_valid,
  output logic               iss_bubble,
  output logic               iss_cont,
  output logic [OP_W-1:0]    iss_opcode,
  output logic [FRAME_W-1:0] iss_frame,
  output logic [ADDR_W-1:0]  iss_addr,
  output logic [DATA_W-1:0]  iss_a,
  output logic [DATA_W-1:0]  iss_b
);
  // program word field helpers
  function automatic logic [OP_W-1:0] w_opcode(input logic [IW_W-1:0] w);
    return w[OP_W-1:0];
  endfunction
  function automatic logic w_dyadic(input logic [IW_W-1:0] w);
    return w[OP_W];
  endfunction
  function automatic logic w_last(input logic [IW_W-1:0] w);
    return w[OP_W+1];
  endfunction
  function automatic logic [RIDX_W-1:0] w_src_a(input logic [IW_W-1:0] w);
    return w[OP_W+2 +: RIDX_W];
  endfunction
  function automatic logic [RIDX_W-1:0] w_src_b(input logic [IW_W-1:0] w);
    return w[OP_W+2+RIDX_W +: RIDX_W];
  endfunction
  // pair ordering: stored side decides where the newcomer goes
  function automatic logic [2*DATA_W-1:0] order_pair(
    input logic              stored_side,
    input logic [DATA_W-1:0] stored_val,
    input logic [DATA_W-1:0] new_val
  );
    return stored_side ? {new_val, stored_val} : {stored_val, new_val};
  endfunction

  logic [IW_W-1:0]   tok_word, thr_word;
  logic              tok_acc, tok_dyadic, tok_hit, tok_fire, tok_park;
  logic              st_side;
  logic [DATA_W-1:0] st_val;
  logic [DATA_W-1:0] tok_opa, tok_opb;
  logic              thr_start, thr_busy, thr_last;
  logic [ADDR_W-1:0] thr_pc;
  logic [FRAME_W-1:0] thr_frame;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic [KEY_W-1:0]  tok_key;

  assign tok_key   = {tok_frame, tok_addr};
  assign tok_ready = !thr_busy;

  tfu_imem #(.ADDR_W(ADDR_W), .IW_W(IW_W)) u_imem (
    .clk       (clk),
    .we        (im_we),
    .waddr     (im_waddr),
    .wdata     (im_wdata),
    .raddr_tok (tok_addr),
    .rdata_tok (tok_word),
    .raddr_thr (thr_pc),
    .rdata_thr (thr_word)
  );

  tfu_match_store #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_key  (tok_key),
    .rd_hit  (tok_hit),
    .rd_port (st_side),
    .rd_data (st_val),
    .wr_set  (tok_park),
    .wr_clr  (tok_fire && tok_dyadic),
    .wr_key  (tok_key),
    .wr_port (tok_port),
    .wr_data (tok_data)
  );

  always_comb begin
    tok_acc    = tok_valid && tok_ready;
    tok_dyadic = w_dyadic(tok_word);
    tok_fire   = tok_acc && (!tok_dyadic || tok_hit);
    tok_park   = tok_acc && tok_dyadic && !tok_hit;
    if (tok_dyadic) begin
      {tok_opa, tok_opb} = order_pair(st_side, st_val, tok_data);
    end else begin
      tok_opa = tok_data;
      tok_opb = '0;
    end
    thr_start = tok_fire && thread_en && !w_last(tok_word);
    thr_last  = w_last(thr_word);
  end

  tfu_thread_seq #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (thr_start),
    .start_addr  (tok_addr),
    .start_frame (tok_frame),
    .cur_last    (thr_last),
    .busy        (thr_busy),
    .pc          (thr_pc),
    .frame       (thr_frame)
  );

  tfu_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (tok_fire),
    .ld_a    (tok_opa),
    .ld_b    (tok_opb),
    .wr_en   (rf_we),
    .wr_idx  (rf_widx),
    .wr_data (rf_wdata),
    .ra_idx  (w_src_a(thr_word)),
    .ra_data (rf_a),
    .rb_idx  (w_src_b(thr_word)),
    .rb_data (rf_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid  <= 1'b0;
      iss_bubble <= 1'b0;
      iss_cont   <= 1'b0;
      iss_opcode <= '0;
      iss_frame  <= '0;
      iss_addr   <= '0;
      iss_a      <= '0;
      iss_b      <= '0;
    end else begin
      iss_bubble <= tok_park;
      if (thr_busy) begin
        iss_valid  <= 1'b1;
        iss_cont   <= 1'b1;
        iss_opcode <= w_opcode(thr_word);
        iss_frame  <= thr_frame;
        iss_addr   <= thr_pc;
        iss_a      <= rf_a;
        iss_b      <= rf_b;
      end else if (tok_fire) begin
        iss_valid  <= 1'b1;
        iss_cont   <= 1'b0;
        iss_opcode <= w_opcode(tok_word);
        iss_frame  <= tok_frame;
        iss_addr   <= tok_addr;
        iss_a      <= tok_opa;
        iss_b      <= tok_opb;
      end else begin
        iss_valid  <= 1'b0;
        iss_cont   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tfu_sva.sv
module tfu_sva (
  input logic clk,
  input logic rst_n,
  input logic tok_valid,
  input logic tok_ready,
  input logic tok_dyadic,
  input logic tok_hit,
  input logic tok_park,
  input logic iss_valid,
  input logic iss_bubble,
  input logic iss_cont
);
  AST_BUBBLE_NOT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_bubble |-> !iss_valid); // R3

  AST_PARK_GIVES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_park |=> (iss_bubble && !iss_valid)); // R3

  AST_MONADIC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && !tok_dyadic) |=> (iss_valid && !iss_cont)); // R2

  AST_PAIR_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_dyadic && tok_hit) |=> (iss_valid && !iss_bubble)); // R4

  AST_THREAD_BLOCKS_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_cont |-> !$past(tok_ready)); // R8

  AST_CONT_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_cont |-> (iss_valid && !iss_bubble)); // R8
endmodule

bind tok_fire_unit tfu_sva u_tfu_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .tok_valid  (tok_valid),
  .tok_ready  (tok_ready),
  .tok_dyadic (tok_dyadic),
  .tok_hit    (tok_hit),
  .tok_park   (tok_park),
  .iss_valid  (iss_valid),
  .iss_bubble (iss_bubble),
  .iss_cont   (iss_cont)
);

// File: tb/test_tok_fire_unit.sv
`timescale 1ns/1ps
module test_tok_fire_unit;
  localparam int FRAME_W = 2;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 6;
  localparam int NREG    = 4;
  localparam int RIDX_W  = 2;
  localparam int IW_W    = OP_W + 2 + 2 * RIDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thread_en = 1'b0;
  logic tok_valid = 1'b0;
  logic tok_ready;
  logic [FRAME_W-1:0] tok_frame = '0;
  logic [ADDR_W-1:0]  tok_addr = '0;
  logic tok_port = 1'b0;
  logic [DATA_W-1:0] tok_data = '0;
  logic im_we = 1'b0;
  logic [ADDR_W-1:0] im_waddr = '0;
  logic [IW_W-1:0] im_wdata = '0;
  logic rf_we = 1'b0;
  logic [RIDX_W-1:0] rf_widx = '0;
  logic [DATA_W-1:0] rf_wdata = '0;
  logic iss_valid, iss_bubble, iss_cont;
  logic [OP_W-1:0] iss_opcode;
  logic [FRAME_W-1:0] iss_frame;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_a, iss_b;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tok_fire_unit #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .OP_W(OP_W), .NREG(NREG)) i_tok_fire_unit (
    .clk(clk), .rst_n(rst_n), .thread_en(thread_en),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_frame(tok_frame),
    .tok_addr(tok_addr), .tok_port(tok_port), .tok_data(tok_data),
    .im_we(im_we), .im_waddr(im_waddr), .im_wdata(im_wdata),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
    .iss_valid(iss_valid), .iss_bubble(iss_bubble), .iss_cont(iss_cont),
    .iss_opcode(iss_opcode), .iss_frame(iss_frame), .iss_addr(iss_addr),
    .iss_a(iss_a), .iss_b(iss_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // word layout per R7: {srcB, srcA, last, dyadic, opcode}
  task automatic prog(input logic [ADDR_W-1:0] a, input logic [OP_W-1:0] op,
                      input bit dy, input bit last,
                      input logic [RIDX_W-1:0] sa, input logic [RIDX_W-1:0] sb);
    im_we    = 1'b1;
    im_waddr = a;
    im_wdata = {sb, sa, last, dy, op};
    @(negedge clk);
    im_we = 1'b0;
  endtask

  task automatic send(input logic [FRAME_W-1:0] f, input logic [ADDR_W-1:0] a,
                      input bit p, input logic [DATA_W-1:0] d);
    tok_valid = 1'b1;
    tok_frame = f;
    tok_addr  = a;
    tok_port  = p;
    tok_data  = d;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic expect_fire(input string tag, input logic [OP_W-1:0] op,
                             input logic [FRAME_W-1:0] f, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    chk_eq({tag, " valid"}, iss_valid, 1);
    chk_eq({tag, " bubble"}, iss_bubble, 0);
    chk_eq({tag, " opcode"}, iss_opcode, op);
    chk_eq({tag, " frame"}, iss_frame, f);
    chk_eq({tag, " addr"}, iss_addr, a);
    chk_eq({tag, " opA"}, iss_a, x);
    chk_eq({tag, " opB"}, iss_b, y);
  endtask

  task automatic expect_bubble(input string tag);
    chk_eq({tag, " valid"}, iss_valid, 0);
    chk_eq({tag, " bubble"}, iss_bubble, 1);
  endtask

  task automatic t_reset();
    chk_eq("R1 ready after reset", tok_ready, 1);
    chk_eq("R1 no issue after reset", iss_valid, 0);
    chk_eq("R1 no bubble after reset", iss_bubble, 0);
    chk_eq("R1 no cont after reset", iss_cont, 0);
  endtask

  task automatic t_monadic();
    send(0, 2, 0, 16'h0055);
    expect_fire("R2 monadic", 6'h05, 0, 2, 16'h0055, 16'h0000);
    chk_eq("R2 monadic cont", iss_cont, 0);
    @(negedge clk);
    chk_eq("R2 single issue", iss_valid, 0);
  endtask

  task automatic t_order();
    send(1, 3, 0, 16'h0111);
    expect_bubble("R3 first left");
    send(1, 3, 1, 16'h0222);
    expect_fire("R4 left-then-right", 6'h0A, 1, 3, 16'h0111, 16'h0222);
    send(2, 3, 1, 16'h0333);
    expect_bubble("R3 first right");
    send(2, 3, 0, 16'h0444);
    expect_fire("R4 right-then-left", 6'h0A, 2, 3, 16'h0444, 16'h0333);
    send(1, 3, 0, 16'h0999);
    expect_bubble("R4 slot freed after match");
    send(1, 3, 1, 16'h0001);
    expect_fire("R4 refill pair", 6'h0A, 1, 3, 16'h0999, 16'h0001);
  endtask

  task automatic t_interleave();
    int fires = 0;
    int bubbles = 0;
    send(0, 3, 0, 16'h00A0); bubbles += int'(iss_bubble);
    send(0, 7, 0, 16'h00B0); bubbles += int'(iss_bubble);
    send(3, 3, 1, 16'h00C0); bubbles += int'(iss_bubble);
    send(0, 3, 1, 16'h00A1); fires += int'(iss_valid);
    expect_fire("R6 frame0 addr3", 6'h0A, 0, 3, 16'h00A0, 16'h00A1);
    send(3, 3, 0, 16'h00C1); fires += int'(iss_valid);
    expect_fire("R6 frame3 addr3", 6'h0A, 3, 3, 16'h00C1, 16'h00C0);
    send(0, 7, 1, 16'h00B1); fires += int'(iss_valid);
    expect_fire("R6 frame0 addr7", 6'h0B, 0, 7, 16'h00B0, 16'h00B1);
    @(negedge clk); fires += int'(iss_valid);
    chk_eq("R4 each pair issued exactly once", fires, 3);
    chk_eq("R3 each first arrival bubbled", bubbles, 3);
  endtask

  task automatic t_same_port();
    send(1, 3, 1, 16'h0010);
    expect_bubble("R5 park right");
    send(1, 3, 1, 16'h0020);
    expect_fire("R5 right twice", 6'h0A, 1, 3, 16'h0020, 16'h0010);
    send(2, 3, 0, 16'h0030);
    send(2, 3, 0, 16'h0040);
    expect_fire("R5 left twice", 6'h0A, 2, 3, 16'h0030, 16'h0040);
  endtask

  task automatic t_thread();
    rf_we = 1'b1; rf_widx = 2; rf_wdata = 16'h0777;
    @(negedge clk);
    rf_we = 1'b0;
    thread_en = 1'b1;
    send(1, 4, 0, 16'h0100);
    expect_bubble("R8 head first operand");
    send(1, 4, 1, 16'h0200);
    expect_fire("R8 head", 6'h11, 1, 4, 16'h0100, 16'h0200);
    chk_eq("R8 head cont", iss_cont, 0);
    chk_eq("R8 ready low in thread", tok_ready, 0);
    tok_valid = 1'b1; tok_frame = 0; tok_addr = 2; tok_port = 0; tok_data = 16'h0066;
    @(negedge clk);
    expect_fire("R9 second word from r0 r1", 6'h12, 1, 5, 16'h0100, 16'h0200);
    chk_eq("R8 second word cont", iss_cont, 1);
    chk_eq("R8 ready still low", tok_ready, 0);
    @(negedge clk);
    expect_fire("R9 last word from r2 r0", 6'h13, 1, 6, 16'h0777, 16'h0100);
    chk_eq("R8 last word cont", iss_cont, 1);
    chk_eq("R8 ready back after last", tok_ready, 1);
    @(negedge clk);
    tok_valid = 1'b0;
    expect_fire("R8 held token taken after thread", 6'h05, 0, 2, 16'h0066, 16'h0000);
    chk_eq("R8 held token not a continuation", iss_cont, 0);
    @(negedge clk);
  endtask

  task automatic t_no_thread();
    thread_en = 1'b0;
    send(2, 4, 1, 16'h0202);
    send(2, 4, 0, 16'h0101);
    expect_fire("R10 head alone", 6'h11, 2, 4, 16'h0101, 16'h0202);
    chk_eq("R10 ready stays high", tok_ready, 1);
    @(negedge clk);
    chk_eq("R10 no continuation", iss_valid, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    prog(2, 6'h05, 0, 1, 0, 0);
    prog(3, 6'h0A, 1, 1, 0, 0);
    prog(7, 6'h0B, 1, 1, 0, 0);
    prog(4, 6'h11, 1, 0, 0, 0);
    prog(5, 6'h12, 0, 0, 0, 1);
    prog(6, 6'h13, 0, 1, 2, 0);
    t_monadic();
    t_order();
    t_interleave();
    t_same_port();
    t_thread();
    t_no_thread();
    finish_run();
  end
endmodule